// File: doc/BRIEF.md
# Polyphase Scaler Control Port

This block is the host-facing control slave of a polyphase video scaler. A host reaches it over a simple register bus: one address, a write strobe, write data and read data. It holds a run flag, a status bit, and the width and height of the next output frame. It also manages two coefficient stores, one for horizontal filtering and one for vertical filtering. Each store holds several banks, each bank holds several phases, and each phase holds one value per tap.

The host loads coefficients in two steps. It first writes every tap value of one phase into staging registers. It then writes the phase number to that direction's phase register. That write copies all staged taps at once into the direction's current write bank, at the phase just written. Each direction has its own write-bank and read-bank selectors. The host can therefore fill one bank while the scaler keeps filtering from another.

Toward the datapath the block offers a frame handshake. The datapath requests a frame start. A grant comes back only while the run flag is set. At the grant, the frame dimensions and both read-bank selectors are frozen into shadow registers for the whole frame. The datapath fetches coefficients through a combinational port, addressed by direction, phase and tap, which always uses the frozen read bank.

Top module: `scl_ctrl_port`

## Requirements
- R1: After a synchronous reset, the run flag, status, width, height, and all bank, phase and staging registers read 0. The grant and busy outputs are 0 and the frame dimension outputs are 0.
- R2: Address 0 holds the run flag in bit 0. Only bit 0 is stored, so bits 31..1 always read 0.
- R3: Address 2 and every address above 10+NTAPS ignore writes and read as 0.
- R4: Address 3 (width, DIMW bits) and address 4 (height, DIMW bits) read back what was written. The frame dimension outputs change only when a grant is issued, and then take those register values.
- R5: The grant is a one-cycle pulse. It is issued in the cycle after a request is sampled, and only if the run flag is 1 and no frame is in progress.
- R6: Status (address 1, bit 0, read-only) and the busy output go to 1 with the grant. They stay 1 until a frame-end pulse is sampled while busy, even if the run flag is cleared meanwhile.
- R7: Every write to address 9 copies the staged taps (addresses 11..10+NTAPS, tap 0 at address 11) into the horizontal store, in the bank held at address 5 and the phase given by the written value. The coefficient port shows the result right after that write's clock edge.
- R8: A phase-register write commits again even when the phase value equals the previous write.
- R9: A commit into a bank other than the frozen read bank does not change what the coefficient port returns.
- R10: The read banks (address 6 horizontal, address 8 vertical) take effect on the coefficient port only at the next grant.
- R11: A commit with a write bank ≥ NBANKS or a phase ≥ NPHASES is dropped, and no stored coefficient changes.
- R12: Bank and phase registers (addresses 5..10, IDXW bits) and staging registers (DW bits) read back their last written values.
- R13: A write to address 10 commits into the vertical store, using the write bank at address 7. Coefficient direction 1 selects the vertical store and direction 0 the horizontal store, and a commit to one never alters the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | BUSW | Register write data |
| bus_rdata | output | BUSW | Registered read data for the address of the previous cycle |
| dp_frame_req | input | 1 | Datapath asks to start a frame |
| dp_frame_end | input | 1 | Datapath reports the end of the current frame |
| dp_frame_gnt | output | 1 | One-cycle grant of a frame start |
| frm_busy | output | 1 | Frame in progress |
| frm_width | output | DIMW | Width frozen for the current frame |
| frm_height | output | DIMW | Height frozen for the current frame |
| coef_dir | input | 1 | 0 selects horizontal, 1 selects vertical |
| coef_phase | input | clog2(NPHASES) | Phase to read |
| coef_tap | input | clog2(NTAPS) | Tap to read |
| coef_data | output | DW | Coefficient from the frozen read bank |

## Verification
Each result has its own latency, and the bench samples at the falling edge that follows the edge producing it. A register read returns data one rising edge after the address is applied. A grant, a busy change or a new frozen dimension appears one edge after the request or frame-end is sampled. The coefficient port is combinational, so a committed tap is visible just after the phase write's edge and is checked a few nanoseconds after its inputs settle. Hold-off behaviour is checked by applying the stimulus that could disturb an output and then reading that output before the next frame boundary. This covers dimension and read-bank changes mid-frame, commits to another bank, and dropped commits.

// File: rtl/scl_ctrl_pkg.sv
package scl_ctrl_pkg;
  localparam int A_CTRL       = 0;
  localparam int A_STAT       = 1;
  localparam int A_RSVD       = 2;
  localparam int A_WIDTH      = 3;
  localparam int A_HEIGHT     = 4;
  localparam int A_BANK_BASE  = 5;
  localparam int A_PHASE_BASE = 9;
  localparam int A_TAP0       = 11;
  localparam int NDIR         = 2;

  // direction 0 = horizontal, 1 = vertical
  function automatic int wbank_addr(input int d);
    return A_BANK_BASE + 2 * d;
  endfunction

  function automatic int rbank_addr(input int d);
    return A_BANK_BASE + 2 * d + 1;
  endfunction

  function automatic int phase_addr(input int d);
    return A_PHASE_BASE + d;
  endfunction
endpackage

// File: rtl/scl_coef_bank.sv
module scl_coef_bank #(
  parameter int NTAPS   = 4,
  parameter int NPHASES = 8,
  parameter int NBANKS  = 2,
  parameter int DW      = 32,
  parameter int IDXW    = 8,
  localparam int PHW    = (NPHASES > 1) ? $clog2(NPHASES) : 1,
  localparam int TAPW   = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
  input  logic                  clk,
  input  logic                  commit,
  input  logic [IDXW-1:0]       wbank,
  input  logic [IDXW-1:0]       wphase,
  input  logic [NTAPS*DW-1:0]   wtaps,
  input  logic [IDXW-1:0]       rbank,
  input  logic [PHW-1:0]        rphase,
  input  logic [TAPW-1:0]       rtap,
  output logic [DW-1:0]         rdata
);
  localparam int ROWS = NBANKS * NPHASES;
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;

  // one row per (bank, phase) holds every tap of that phase
  logic [NTAPS*DW-1:0] mem [ROWS];
  logic                w_ok;
  logic [RW-1:0]       widx;
  logic [RW-1:0]       ridx;
  logic                rb_ok;
  logic                ph_ok;
  logic                tap_ok;
  logic [NTAPS*DW-1:0] row;

  assign w_ok = commit && (wbank < IDXW'(NBANKS)) && (wphase < IDXW'(NPHASES));
  assign widx = RW'(wbank) * RW'(NPHASES) + RW'(wphase);

  always_ff @(posedge clk) begin
    if (w_ok) mem[widx] <= wtaps;
  end

  assign rb_ok = (rbank < IDXW'(NBANKS));

  generate
    if ((1 << PHW) == NPHASES) begin : g_ph_full
      assign ph_ok = 1'b1;
    end else begin : g_ph_part
      assign ph_ok = (rphase < PHW'(NPHASES));
    end
    if ((1 << TAPW) == NTAPS) begin : g_tap_full
      assign tap_ok = 1'b1;
    end else begin : g_tap_part
      assign tap_ok = (rtap < TAPW'(NTAPS));
    end
  endgenerate

  assign ridx  = RW'(rbank) * RW'(NPHASES) + RW'(rphase);
  assign row   = mem[ridx];
  assign rdata = (rb_ok && ph_ok && tap_ok) ? row[int'(rtap) * DW +: DW] : '0;
endmodule

// File: rtl/scl_frame_ctl.sv
module scl_frame_ctl #(
  parameter int DIMW = 16,
  parameter int IDXW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic                 req,
  input  logic                 fend,
  input  logic [DIMW-1:0]      live_w,
  input  logic [DIMW-1:0]      live_h,
  input  logic [1:0][IDXW-1:0] live_rb,
  output logic                 gnt,
  output logic                 busy,
  output logic [DIMW-1:0]      sh_w,
  output logic [DIMW-1:0]      sh_h,
  output logic [1:0][IDXW-1:0] sh_rb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gnt   <= 1'b0;
      busy  <= 1'b0;
      sh_w  <= '0;
      sh_h  <= '0;
      sh_rb <= '0;
    end else begin
      gnt <= 1'b0;
      if (busy && fend) busy <= 1'b0;
      if (req && go && !busy) begin
        gnt   <= 1'b1;
        busy  <= 1'b1;
        sh_w  <= live_w;
        sh_h  <= live_h;
        sh_rb <= live_rb;
      end
    end
  end
endmodule

// File: rtl/scl_ctrl_port.sv
module scl_ctrl_port
  import scl_ctrl_pkg::*;
#(
  parameter int BUSW    = 32,
  parameter int AW      = 5,
  parameter int NTAPS   = 4,
  parameter int NPHASES = 8,
  parameter int NBANKS  = 2,
  parameter int DW      = 32,
  parameter int DIMW    = 16,
  parameter int IDXW    = 8,
  localparam int PHW    = (NPHASES > 1) ? $clog2(NPHASES) : 1,
  localparam int TAPW   = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [BUSW-1:0] bus_wdata,
  output logic [BUSW-1:0] bus_rdata,
  input  logic            dp_frame_req,
  input  logic            dp_frame_end,
  output logic            dp_frame_gnt,
  output logic            frm_busy,
  output logic [DIMW-1:0] frm_width,
  output logic [DIMW-1:0] frm_height,
  input  logic            coef_dir,
  input  logic [PHW-1:0]  coef_phase,
  input  logic [TAPW-1:0] coef_tap,
  output logic [DW-1:0]   coef_data
);
  logic                        go_q;
  logic [DIMW-1:0]             width_q;
  logic [DIMW-1:0]             height_q;
  logic [NDIR-1:0][IDXW-1:0]   wb_q;
  logic [NDIR-1:0][IDXW-1:0]   rb_q;
  logic [NDIR-1:0][IDXW-1:0]   ph_q;
  logic [NTAPS-1:0][DW-1:0]    stage_q;
  logic [NDIR-1:0]             commit;
  logic [NDIR-1:0][IDXW-1:0]   sh_rb;
  logic [BUSW-1:0]             rd_mux;

  // host register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      go_q     <= 1'b0;
      width_q  <= '0;
      height_q <= '0;
      wb_q     <= '0;
      rb_q     <= '0;
      ph_q     <= '0;
      stage_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == AW'(A_CTRL))   go_q     <= bus_wdata[0];
      if (bus_addr == AW'(A_WIDTH))  width_q  <= bus_wdata[DIMW-1:0];
      if (bus_addr == AW'(A_HEIGHT)) height_q <= bus_wdata[DIMW-1:0];
      for (int d = 0; d < NDIR; d++) begin
        if (bus_addr == AW'(wbank_addr(d))) wb_q[d] <= bus_wdata[IDXW-1:0];
        if (bus_addr == AW'(rbank_addr(d))) rb_q[d] <= bus_wdata[IDXW-1:0];
        if (bus_addr == AW'(phase_addr(d))) ph_q[d] <= bus_wdata[IDXW-1:0];
      end
      for (int t = 0; t < NTAPS; t++) begin
        if (bus_addr == AW'(A_TAP0 + t)) stage_q[t] <= bus_wdata[DW-1:0];
      end
    end
  end

  // a phase write is the commit strobe of its direction
  always_comb begin
    for (int d = 0; d < NDIR; d++) begin
      commit[d] = bus_wr && (bus_addr == AW'(phase_addr(d)));
    end
  end

  // read mux, registered below
  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(A_CTRL))   rd_mux = BUSW'(go_q);
    if (bus_addr == AW'(A_STAT))   rd_mux = BUSW'(frm_busy);
    if (bus_addr == AW'(A_WIDTH))  rd_mux = BUSW'(width_q);
    if (bus_addr == AW'(A_HEIGHT)) rd_mux = BUSW'(height_q);
    for (int d = 0; d < NDIR; d++) begin
      if (bus_addr == AW'(wbank_addr(d))) rd_mux = BUSW'(wb_q[d]);
      if (bus_addr == AW'(rbank_addr(d))) rd_mux = BUSW'(rb_q[d]);
      if (bus_addr == AW'(phase_addr(d))) rd_mux = BUSW'(ph_q[d]);
    end
    for (int t = 0; t < NTAPS; t++) begin
      if (bus_addr == AW'(A_TAP0 + t)) rd_mux = BUSW'(stage_q[t]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  scl_frame_ctl #(
    .DIMW (DIMW),
    .IDXW (IDXW)
  ) u_frame (
    .clk     (clk),
    .rst     (rst),
    .go      (go_q),
    .req     (dp_frame_req),
    .fend    (dp_frame_end),
    .live_w  (width_q),
    .live_h  (height_q),
    .live_rb (rb_q),
    .gnt     (dp_frame_gnt),
    .busy    (frm_busy),
    .sh_w    (frm_width),
    .sh_h    (frm_height),
    .sh_rb   (sh_rb)
  );

  generate
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
      logic [DW-1:0] q;
      scl_coef_bank #(
        .NTAPS   (NTAPS),
        .NPHASES (NPHASES),
        .NBANKS  (NBANKS),
        .DW      (DW),
        .IDXW    (IDXW)
      ) u_bank (
        .clk    (clk),
        .commit (commit[d]),
        .wbank  (wb_q[d]),
        .wphase (bus_wdata[IDXW-1:0]),
        .wtaps  (stage_q),
        .rbank  (sh_rb[d]),
        .rphase (coef_phase),
        .rtap   (coef_tap),
        .rdata  (q)
      );
    end
  endgenerate

  assign coef_data = coef_dir ? g_dir[1].q : g_dir[0].q;
endmodule

// File: rtl/scl_ctrl_port_chk.sv
module scl_ctrl_port_chk #(
  parameter int BUSW = 32,
  parameter int AW   = 5,
  parameter int DIMW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            go,
  input logic            req,
  input logic            fend,
  input logic            gnt,
  input logic            busy,
  input logic [AW-1:0]   bus_addr,
  input logic [BUSW-1:0] bus_rdata,
  input logic [DIMW-1:0] frm_width,
  input logic [DIMW-1:0] frm_height
);
  p_ctrl_bits_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == AW'(0)) |-> (bus_rdata[BUSW-1:1] == '0));

  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == AW'(2)) |-> (bus_rdata == '0));

  p_dims_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    !gnt |-> ($stable(frm_width) && $stable(frm_height)));

  p_gnt_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    gnt |=> !gnt);

  p_gnt_needs_go_r5: assert property (@(posedge clk) disable iff (rst)
    gnt |-> $past(go && req));

  p_gnt_sets_busy_r6: assert property (@(posedge clk) disable iff (rst)
    gnt |-> busy);

  p_end_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && fend) |=> !busy);

  p_busy_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !fend) |=> busy);
endmodule

bind scl_ctrl_port scl_ctrl_port_chk #(
  .BUSW (BUSW),
  .AW   (AW),
  .DIMW (DIMW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .go         (go_q),
  .req        (dp_frame_req),
  .fend       (dp_frame_end),
  .gnt        (dp_frame_gnt),
  .busy       (frm_busy),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .frm_width  (frm_width),
  .frm_height (frm_height)
);

// File: tb/scl_ctrl_port_tb.sv
module scl_ctrl_port_tb;
  localparam int BUSW = 32;
  localparam int AW   = 5;
  localparam int DW   = 32;
  localparam int DIMW = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_wr = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [BUSW-1:0] bus_wdata = '0;
  logic [BUSW-1:0] bus_rdata;
  logic            dp_frame_req = 1'b0;
  logic            dp_frame_end = 1'b0;
  logic            dp_frame_gnt;
  logic            frm_busy;
  logic [DIMW-1:0] frm_width;
  logic [DIMW-1:0] frm_height;
  logic            coef_dir = 1'b0;
  logic [2:0]      coef_phase = '0;
  logic [1:0]      coef_tap = '0;
  logic [DW-1:0]   coef_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  scl_ctrl_port u_dut (
    .clk          (clk),
    .rst          (rst),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .dp_frame_req (dp_frame_req),
    .dp_frame_end (dp_frame_end),
    .dp_frame_gnt (dp_frame_gnt),
    .frm_busy     (frm_busy),
    .frm_width    (frm_width),
    .frm_height   (frm_height),
    .coef_dir     (coef_dir),
    .coef_phase   (coef_phase),
    .coef_tap     (coef_tap),
    .coef_data    (coef_data)
  );

  // {req tag, address, write data, expected read-back}
  localparam int NV = 13;
  localparam logic [75:0] VEC [NV] = '{
    {4'd2,  8'd0,  32'hFFFF_FFFF, 32'h0000_0001},  // R2 only bit 0 kept
    {4'd2,  8'd0,  32'h0000_0000, 32'h0000_0000},  // R2
    {4'd3,  8'd2,  32'hDEAD_BEEF, 32'h0000_0000},  // R3 reserved
    {4'd3,  8'd15, 32'h0000_0005, 32'h0000_0000},  // R3 above taps
    {4'd3,  8'd31, 32'hFFFF_FFFF, 32'h0000_0000},  // R3 top address
    {4'd4,  8'd3,  32'h0001_2345, 32'h0000_2345},  // R4 width DIMW bits
    {4'd4,  8'd4,  32'h0000_0438, 32'h0000_0438},  // R4 height
    {4'd12, 8'd5,  32'h0000_0001, 32'h0000_0001},  // R12 h write bank
    {4'd12, 8'd6,  32'h0000_0000, 32'h0000_0000},  // R12 h read bank
    {4'd12, 8'd7,  32'h0000_01FF, 32'h0000_00FF},  // R12 IDXW bits
    {4'd12, 8'd8,  32'h0000_0001, 32'h0000_0001},  // R12 v read bank
    {4'd12, 8'd11, 32'hABCD_1234, 32'hABCD_1234},  // R12 staging tap 0
    {4'd6,  8'd1,  32'h0000_0001, 32'h0000_0000}   // R6 status read-only
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [BUSW-1:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = AW'(a);
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [BUSW-1:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic cchk(input string tag, input logic dir, input int ph, input int tap,
                      input logic [DW-1:0] exp);
    coef_dir   = dir;
    coef_phase = 3'(ph);
    coef_tap   = 2'(tap);
    #1;
    chk(tag, 64'(coef_data), 64'(exp));
  endtask

  task automatic frame_end();
    @(negedge clk);
    dp_frame_end = 1'b1;
    @(negedge clk);
    dp_frame_end = 1'b0;
  endtask

  task automatic request(output logic g);
    @(negedge clk);
    dp_frame_req = 1'b1;
    @(negedge clk);
    g = dp_frame_gnt;
    dp_frame_req = 1'b0;
  endtask

  task automatic stage4(input logic [DW-1:0] a, b, c, d);
    wr(11, a); wr(12, b); wr(13, c); wr(14, d);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [BUSW-1:0] r;
    logic            g;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 grant", 64'(dp_frame_gnt), 64'd0);
    chk("R1 busy", 64'(frm_busy), 64'd0);
    chk("R1 frm_width", 64'(frm_width), 64'd0);
    rd(0, r); chk("R1 ctrl", 64'(r), 64'd0);
    rd(1, r); chk("R1 status", 64'(r), 64'd0);
    rd(3, r); chk("R1 width", 64'(r), 64'd0);
    rd(11, r); chk("R1 stage", 64'(r), 64'd0);

    // table walk: write, then read back
    for (int i = 0; i < NV; i++) begin
      wr(int'(VEC[i][71:64]), VEC[i][63:32]);
      rd(int'(VEC[i][71:64]), r);
      n_chk++;
      if (r !== VEC[i][31:0]) begin
        n_fail++;
        $display("FAIL R%0d vector %0d actual=%0h expected=%0h",
                 VEC[i][75:72], i, r, VEC[i][31:0]);
      end
    end

    // load H bank0 phase2, start a frame (R7, R5, R6, R4)
    wr(5, 0); wr(7, 0); wr(8, 0);
    stage4(32'h11, 32'h22, 32'h33, 32'h44);
    wr(9, 2);
    wr(3, 640); wr(4, 480); wr(0, 1);
    @(negedge clk);
    dp_frame_req = 1'b1;
    @(negedge clk);
    chk("R5 grant issued", 64'(dp_frame_gnt), 64'd1);
    chk("R6 busy on grant", 64'(frm_busy), 64'd1);
    chk("R4 width latched", 64'(frm_width), 64'd640);
    chk("R4 height latched", 64'(frm_height), 64'd480);
    @(negedge clk);
    chk("R5 grant one cycle", 64'(dp_frame_gnt), 64'd0);
    dp_frame_req = 1'b0;
    rd(1, r); chk("R6 status busy", 64'(r), 64'd1);
    cchk("R7 tap0", 1'b0, 2, 0, 32'h11);
    cchk("R7 tap1", 1'b0, 2, 1, 32'h22);
    cchk("R7 tap2", 1'b0, 2, 2, 32'h33);
    cchk("R7 tap3", 1'b0, 2, 3, 32'h44);

    // R4 mid-frame dimension change held off
    wr(3, 800);
    chk("R4 width held", 64'(frm_width), 64'd640);
    // R10 read bank change held off
    wr(6, 1);
    cchk("R10 old bank kept", 1'b0, 2, 0, 32'h11);
    // R9 write other bank while reading bank 0
    wr(5, 1);
    stage4(32'h55, 32'h66, 32'h77, 32'h88);
    wr(9, 2);
    cchk("R9 read bank untouched", 1'b0, 2, 1, 32'h22);

    // R6 stop only at boundary, R5 no grant while go low
    wr(0, 0);
    rd(1, r); chk("R6 busy after go cleared", 64'(r), 64'd1);
    frame_end();
    chk("R6 busy cleared by end", 64'(frm_busy), 64'd0);
    rd(1, r); chk("R6 status idle", 64'(r), 64'd0);
    request(g);
    chk("R5 no grant with go low", 64'(g), 64'd0);

    // new frame picks up bank 1 and width 800
    wr(0, 1);
    request(g);
    chk("R5 grant with go high", 64'(g), 64'd1);
    chk("R4 new width", 64'(frm_width), 64'd800);
    cchk("R10 new bank tap0", 1'b0, 2, 0, 32'h55);
    cchk("R10 new bank tap3", 1'b0, 2, 3, 32'h88);

    // R8 same phase committed again
    wr(11, 32'h99);
    wr(9, 2);
    cchk("R8 recommit tap0", 1'b0, 2, 0, 32'h99);
    cchk("R8 recommit tap1", 1'b0, 2, 1, 32'h66);

    // R11 dropped commits
    wr(11, 32'h7777);
    wr(9, 8);
    cchk("R11 phase out of range", 1'b0, 2, 0, 32'h99);
    wr(5, 2);
    wr(9, 2);
    cchk("R11 bank out of range", 1'b0, 2, 0, 32'h99);
    rd(5, r); chk("R12 bank readback", 64'(r), 64'd2);
    rd(9, r); chk("R12 phase readback", 64'(r), 64'd2);
    // bank 2 phase 2 must not alias onto bank 0 phase 2
    wr(6, 0);
    frame_end();
    request(g);
    chk("R5 regrant", 64'(g), 64'd1);
    cchk("R11 no alias write", 1'b0, 2, 0, 32'h11);

    // R13 vertical store independent
    stage4(32'hA1, 32'hA2, 32'hA3, 32'hA4);
    wr(10, 5);
    cchk("R13 vertical tap3", 1'b1, 5, 3, 32'hA4);
    cchk("R13 vertical tap0", 1'b1, 5, 0, 32'hA1);
    cchk("R13 horizontal intact", 1'b0, 2, 0, 32'h11);
    rd(10, r); chk("R12 v phase readback", 64'(r), 64'd5);
    frame_end();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule